// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block decides, cycle by cycle, whether a processor core may take an interrupt and which one. It watches a non-maskable request line and a vector of maskable request pulses. It keeps one pending flag per source and a mask bit per maskable source. It also holds a global disabled state that the core enters each time it takes an interrupt, and a sticky arming flag for the non-maskable line. A status hold input freezes acceptance without losing requests: requests that arrive while it is high are latched, and the survivors are judged again as soon as it falls.

The non-maskable line stays blocked by hardware after reset until the boot-mode input, which marks that on-chip instruction memory is still being loaded, has been seen low once. When a grant is made, the block issues a one-cycle acknowledge with an index. Index 0 always means the non-maskable source and index k+1 means maskable source k. The core side re-enables maskable acceptance with an enable strobe.

Top module: `irq_accept_gate`

## Requirements
- R1: After synchronous reset, `ack` is 0, every mask bit is 1, the disabled state is set and the non-maskable source is not armed.
- R2: The non-maskable source becomes armed on the first clock edge at which `boot_mode` is 0 and then stays armed until reset. A rising edge of `nmi_in` seen while not armed is discarded and never produces an acknowledge.
- R3: Once the non-maskable source is armed, a rising edge of `nmi_in` sets its pending flag. That flag is granted regardless of the mask bits and the disabled state, and the grant clears it.
- R4: While `hold` is 1, no acknowledge is issued, and requests from any source are still latched as pending.
- R5: A pending non-maskable request is acknowledged in the cycle right after `hold` falls: with `hold` driven low before edge E, `ack` is 1 after edge E.
- R6: Maskable source k is granted only when its pending flag is 1, its mask bit is 0, the disabled state is clear and `hold` is 0. A mask bit written to 1 while `hold` is high stops the grant, and the pending flag is kept for later.
- R7: `irq_clr[k]` clears pending flag k. When `irq_clr[k]` and `irq_req[k]` are high in the same cycle, the flag ends up set.
- R8: Each source holds at most one pending request. Several pulses from one source before its grant produce exactly one acknowledge.
- R9: When more than one source is eligible, the non-maskable source wins, and after it the lowest maskable index. At most one grant is made per cycle. `ack_idx` is 0 for the non-maskable source and k+1 for maskable source k.
- R10: `ack` is a registered one-cycle pulse. A request pulse sampled at edge E1 sets its flag, and an eligible flag yields `ack` after edge E1+1. Every grant sets the disabled state. `di_strobe` also sets it and `ei_strobe` clears it, with a grant taking precedence over `ei_strobe` in the same cycle.
- R11: `mask_we` loads `mask_wdata` into the mask bits at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request line, edge sensitive |
| boot_mode | input | 1 | High while instruction memory is still being loaded; its first low sample arms the non-maskable source |
| hold | input | 1 | Status hold bit; blocks every acknowledge while high |
| irq_req | input | N_SRC | Maskable request pulses, one per source |
| irq_clr | input | N_SRC | Software clear strobes for the maskable pending flags |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | N_SRC | New mask value (1 = masked) |
| ei_strobe | input | 1 | Clears the disabled state |
| di_strobe | input | 1 | Sets the disabled state |
| ack | output | 1 | One-cycle acknowledge pulse |
| ack_idx | output | IDX_W | Granted source: 0 = non-maskable, k+1 = maskable source k |

## Verification
The bench raises the non-maskable line while `boot_mode` is still high. A gate that latched that edge, or that never armed, would either answer too early or stay silent for good. It lets requests pile up under `hold` and then checks that the non-maskable one is answered exactly one cycle after release and that duplicated pulses collapse into one acknowledge; a gate that lost held requests or counted every pulse fails here. It also cancels one held request with a clear strobe, masks another while held, and fires a clear together with a request. A design that ignored the clear, checked the mask too early or let the clear win would give the wrong acknowledge count. Simultaneous requests then check the order: non-maskable first, then the lowest maskable index, each one only after re-enabling.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned NMI_CODE = 0;

  function automatic int unsigned src_code(input int unsigned k);
    return k + 1;
  endfunction
endpackage

// File: rtl/ig_nmi_ctl.sv
module ig_nmi_ctl (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic boot_mode,
  input  logic nmi_gnt,
  output logic nmi_pend,
  output logic armed
);
  logic nmi_prev;
  logic rise;

  assign rise = nmi_in & ~nmi_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev <= 1'b0;
      armed    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      armed    <= armed | ~boot_mode;
      nmi_pend <= (armed & rise) | (nmi_pend & ~nmi_gnt);
    end
  end

  // R2
  armed_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  // R3
  nmi_gnt_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_gnt |-> nmi_pend);
endmodule

// File: rtl/ig_src_bank.sv
module ig_src_bank #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_clr,
  input  logic [N_SRC-1:0] gnt,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[k] <= 1'b0;
      end else begin
        pend_q[k] <= irq_req[k] | (pend_q[k] & ~irq_clr[k] & ~gnt[k]);
      end
    end

    // R7
    req_wins_chk: assert property (@(posedge clk) disable iff (rst)
      irq_req[k] |=> pend_q[k]);

    // R6
    grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
      gnt[k] |-> (pend_q[k] && !mask_q[k]));
  end
endmodule

// File: rtl/ig_prio_pick.sv
module ig_prio_pick #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_ok,
  input  logic [N_SRC-1:0] elig,
  output logic             nmi_gnt,
  output logic [N_SRC-1:0] gnt,
  output logic             any_gnt,
  output logic [IDX_W-1:0] gnt_idx
);
  import irq_gate_pkg::*;

  always_comb begin
    nmi_gnt = nmi_ok;
    gnt     = '0;
    gnt_idx = IDX_W'(NMI_CODE);
    if (!nmi_ok) begin
      for (int k = N_SRC - 1; k >= 0; k--) begin
        if (elig[k]) begin
          gnt     = '0;
          gnt[k]  = 1'b1;
          gnt_idx = IDX_W'(src_code(k));
        end
      end
    end
    any_gnt = nmi_gnt | (|gnt);
  end

  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nmi_gnt, gnt}));
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_in,
  input  logic             boot_mode,
  input  logic             hold,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_clr,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             ei_strobe,
  input  logic             di_strobe,
  output logic             ack,
  output logic [IDX_W-1:0] ack_idx
);
  logic             nmi_pend;
  logic             nmi_armed;
  logic             nmi_gnt;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] gnt;
  logic             any_gnt;
  logic [IDX_W-1:0] gnt_idx;
  logic             dis_q;
  logic             nmi_ok;

  ig_nmi_ctl u_nmi (
    .clk      (clk),
    .rst      (rst),
    .nmi_in   (nmi_in),
    .boot_mode(boot_mode),
    .nmi_gnt  (nmi_gnt),
    .nmi_pend (nmi_pend),
    .armed    (nmi_armed)
  );

  ig_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .irq_clr   (irq_clr),
    .gnt       (gnt),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
  );

  assign nmi_ok = nmi_pend & ~hold;
  assign elig   = pend_q & ~mask_q & {N_SRC{~dis_q & ~hold}};

  ig_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .nmi_ok (nmi_ok),
    .elig   (elig),
    .nmi_gnt(nmi_gnt),
    .gnt    (gnt),
    .any_gnt(any_gnt),
    .gnt_idx(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q   <= 1'b1;
      ack     <= 1'b0;
      ack_idx <= '0;
    end else begin
      ack     <= any_gnt;
      ack_idx <= gnt_idx;
      if (any_gnt || di_strobe) begin
        dis_q <= 1'b1;
      end else if (ei_strobe) begin
        dis_q <= 1'b0;
      end
    end
  end

  // R4
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ack);

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R6
  maskable_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_idx != '0) |-> !$past(dis_q));

  // R2
  nmi_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_idx == '0) |-> $past(nmi_armed));
endmodule

// File: tb/test_irq_accept_gate.sv
module test_irq_accept_gate;
  localparam int unsigned N = 8;
  localparam int unsigned IW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nmi_in = 1'b0;
  logic          boot_mode = 1'b1;
  logic          hold = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [N-1:0]  irq_clr = '0;
  logic          mask_we = 1'b0;
  logic [N-1:0]  mask_wdata = '0;
  logic          ei_strobe = 1'b0;
  logic          di_strobe = 1'b0;
  logic          ack;
  logic [IW-1:0] ack_idx;

  int checks = 0;
  int fails = 0;
  int ack_cnt = 0;
  int last_idx = -1;
  bit done = 1'b0;

  irq_accept_gate #(.N_SRC(N)) i_irq_accept_gate (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .boot_mode(boot_mode),
    .hold(hold), .irq_req(irq_req), .irq_clr(irq_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ei_strobe(ei_strobe), .di_strobe(di_strobe),
    .ack(ack), .ack_idx(ack_idx)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (ack) begin
      ack_cnt  = ack_cnt + 1;
      last_idx = int'(ack_idx);
    end
  end

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input int k);
    irq_req[k] = 1'b1; step(1); irq_req[k] = 1'b0;
  endtask

  task automatic pulse_clr(input int k);
    irq_clr[k] = 1'b1; step(1); irq_clr[k] = 1'b0;
  endtask

  task automatic enable_int();
    ei_strobe = 1'b1; step(1); ei_strobe = 1'b0;
  endtask

  task automatic set_mask(input logic [N-1:0] v);
    mask_we = 1'b1; mask_wdata = v; step(1); mask_we = 1'b0;
  endtask

  task automatic t_reset();
    step(1);
    check(int'(ack), 0, "R1", "ack after reset");
    enable_int();
    pulse_req(0);
    step(5);
    check(ack_cnt, 0, "R1", "all sources masked after reset");
    pulse_clr(0);
  endtask

  task automatic t_nmi_boot_block();
    nmi_in = 1'b1; step(5);
    check(ack_cnt, 0, "R2", "nmi before arming");
    boot_mode = 1'b0; step(4);
    check(ack_cnt, 0, "R2", "early nmi edge discarded");
    nmi_in = 1'b0; step(2);
    nmi_in = 1'b1; step(4);
    check(ack_cnt, 1, "R3", "nmi ack count after arming");
    check(last_idx, 0, "R3", "nmi index");
    nmi_in = 1'b0; step(2);
  endtask

  task automatic t_nmi_hold();
    int base;
    base = ack_cnt;
    hold = 1'b1; step(1);
    nmi_in = 1'b1; step(6);
    check(ack_cnt - base, 0, "R4", "nmi blocked by hold");
    hold = 1'b0; step(1);
    check(int'(ack), 1, "R5", "nmi ack right after hold falls");
    check(int'(ack_idx), 0, "R5", "nmi index after hold");
    nmi_in = 1'b0; step(3);
    check(ack_cnt - base, 1, "R3", "nmi flag cleared by ack");
  endtask

  task automatic t_clear_cancel();
    int base;
    set_mask('0);
    enable_int();
    base = ack_cnt;
    hold = 1'b1; step(1);
    pulse_req(2);
    pulse_clr(2);
    pulse_req(3);
    hold = 1'b0; step(4);
    check(ack_cnt - base, 1, "R7", "cleared request not taken");
    check(last_idx, 4, "R6", "surviving held request index");
  endtask

  task automatic t_mask_held();
    int base;
    enable_int();
    base = ack_cnt;
    hold = 1'b1; step(1);
    pulse_req(1);
    set_mask(8'h02);
    hold = 1'b0; step(5);
    check(ack_cnt - base, 0, "R6", "masked while held");
    set_mask('0); step(3);
    check(ack_cnt - base, 1, "R11", "unmask releases kept request");
    check(last_idx, 2, "R6", "index of unmasked source");
  endtask

  task automatic t_duplicates();
    int base;
    enable_int();
    base = ack_cnt;
    hold = 1'b1; step(1);
    pulse_req(5); step(1);
    pulse_req(5); step(1);
    pulse_req(5);
    hold = 1'b0; step(4);
    check(ack_cnt - base, 1, "R8", "duplicates merged");
    check(last_idx, 6, "R8", "duplicate source index");
    enable_int(); step(4);
    check(ack_cnt - base, 1, "R8", "no second ack after re-enable");
  endtask

  task automatic t_priority();
    int base;
    enable_int();
    base = ack_cnt;
    hold = 1'b1; step(1);
    nmi_in = 1'b1; irq_req[0] = 1'b1; irq_req[6] = 1'b1;
    step(1);
    irq_req = '0; nmi_in = 1'b0;
    step(2);
    hold = 1'b0; step(1);
    check(int'(ack), 1, "R9", "first winner ack");
    check(int'(ack_idx), 0, "R9", "nmi wins");
    step(3);
    check(ack_cnt - base, 1, "R10", "disabled after nmi grant");
    enable_int(); step(3);
    check(last_idx, 1, "R9", "lowest maskable next");
    enable_int(); step(3);
    check(last_idx, 7, "R9", "higher maskable last");
    check(ack_cnt - base, 3, "R9", "three grants total");
  endtask

  task automatic t_latency_disable();
    int base;
    base = ack_cnt;
    di_strobe = 1'b1; step(1); di_strobe = 1'b0;
    pulse_req(3); step(4);
    check(ack_cnt - base, 0, "R10", "di_strobe blocks maskable");
    nmi_in = 1'b1; step(3);
    check(ack_cnt - base, 1, "R3", "nmi ignores disabled state");
    nmi_in = 1'b0;
    enable_int(); step(3);
    check(last_idx, 4, "R10", "pending source after enable");
    enable_int();
    pulse_req(3);
    check(int'(ack), 0, "R10", "no ack one negedge after pulse");
    step(1);
    check(int'(ack), 1, "R10", "ack two negedges after pulse");
    step(1);
    check(int'(ack), 0, "R10", "ack lasts one cycle");
  endtask

  task automatic t_clr_with_req();
    int base;
    enable_int();
    base = ack_cnt;
    hold = 1'b1; step(1);
    irq_req[4] = 1'b1; irq_clr[4] = 1'b1; step(1);
    irq_req[4] = 1'b0; irq_clr[4] = 1'b0;
    hold = 1'b0; step(3);
    check(ack_cnt - base, 1, "R7", "request beats clear");
    check(last_idx, 5, "R7", "index for same-cycle clear");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_nmi_boot_block();
    t_nmi_hold();
    t_clear_cancel();
    t_mask_held();
    t_duplicates();
    t_priority();
    t_latency_disable();
    t_clr_with_req();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule